// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation miss by reading page tables from memory on its own. A miss arrives as a 32-bit virtual address plus a context number over a valid/ready request channel. The walker first fetches the root entry from a context table, whose base comes from a configuration input and which is indexed by the context number. It then descends through up to three levels of tables. The virtual address is divided into an 8-bit first index (bits 31:24), a 6-bit second index (bits 23:18), a 6-bit third index (bits 17:12) and a 12-bit page offset (bits 11:0).

Each 32-bit entry carries its kind in bits 1:0: 00 invalid, 01 pointer to the next table (next base in bits 31:2), 10 leaf (page number in bits 31:8, permissions in bits 7:2), 11 reserved. A leaf may appear at the first, second or third level, so a walk can stop early on a large mapping. The result goes out as a one-cycle pulse with the page number, permissions, a level tag and the composed physical address, ready for a translation cache refill. A bad entry ends the walk with a one-cycle fault pulse and the level at which it was found.

Back-pressure: the request channel accepts a walk when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low for the whole walk and comes back high in the cycle of the done or fault pulse, so a waiting request is taken in that same cycle. The memory read request is valid/ready as well: once raised, `mem_rd_valid` and `mem_rd_addr` hold until `mem_rd_ready`. Read data returns on `mem_rsp_valid` with no back-pressure, and only one read is ever outstanding.

Top module: `hw_pt_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_rd_valid`, `walk_done` and `walk_fault` are 0.
- R2: From the cycle after a request is accepted `req_ready` is 0, and it is 1 again in the cycle where `walk_done` or `walk_fault` is high.
- R3: The first read of a walk goes to byte address (table base << 4) + context * 4, using the configured context table base.
- R4: Reads for levels 1, 2 and 3 go to (pointer base << 4) + index * 4, where the pointer base is bits 31:2 of the previous entry and the index is address bits 31:24, 23:18 and 17:12 respectively.
- R5: An entry of kind 00 (invalid) or 11 (reserved) at any level ends the walk with `walk_fault` and `fault_level` set to that level (0 context, 1 to 3 for table levels).
- R6: A leaf found in the context table ends with a fault at level 0; a pointer found at level 3 ends with a fault at level 3.
- R7: A leaf at level 1, 2 or 3 ends with `walk_done`, `leaf_ppn` equal to entry bits 31:8, `leaf_perm` equal to entry bits 7:2 and `leaf_level` equal to the level (1, 2 or 3).
- R8: `leaf_paddr` is {ppn[23:12], va[23:0]} for a level-1 leaf, {ppn[23:6], va[17:0]} for level 2 and {ppn, va[11:0]} for level 3.
- R9: A read request keeps `mem_rd_valid` and `mem_rd_addr` stable until accepted, and no new read is raised before the response to the previous one.
- R10: `walk_done` and `walk_fault` are never high together and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address that missed |
| req_ctx | input | CTX_W | Context number selecting the root |
| ctx_tbl_base | input | 30 | Base of the context table (byte address >> 4) |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 36 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| walk_done | output | 1 | One-cycle pulse: leaf found |
| walk_fault | output | 1 | One-cycle pulse: walk failed |
| fault_level | output | 2 | Level at which the fault was found |
| leaf_level | output | 2 | Level at which the leaf was found |
| leaf_ppn | output | 24 | Page number of the leaf |
| leaf_perm | output | 6 | Permission bits of the leaf |
| leaf_paddr | output | 36 | Physical address of the missed access |

## Verification
The completion pulse of one walk and the acceptance of the next request can fall in the same cycle, because `req_ready` returns together with `walk_done`. The bench holds `req_valid` high with a second address throughout the first walk; in the cycle where `req_ready` rises it checks that `walk_done` is high with the first walk's result, and then checks that the second walk is taken at the next edge and resolves to its own leaf. Memory stalls and long response latency are also applied so that the request-hold and single-outstanding rules are judged under back-pressure.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ENTRY_W  = 32;
  localparam int VA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int L1_IDX_W = 8;
  localparam int L2_IDX_W = 6;
  localparam int L3_IDX_W = 6;
  localparam int L3_LO    = OFF_W;
  localparam int L2_LO    = L3_LO + L3_IDX_W;
  localparam int L1_LO    = L2_LO + L2_IDX_W;
  localparam int PERM_LO  = 2;
  localparam int PERM_W   = 6;
  localparam int PPN_LO   = PERM_LO + PERM_W;
  localparam int PPN_W    = ENTRY_W - PPN_LO;
  localparam int BASE_W   = ENTRY_W - 2;
  localparam int PA_W     = PPN_W + OFF_W;
  localparam int TBL_SHIFT = 4;
  localparam int ENT_SHIFT = 2;

  typedef enum logic [1:0] {
    ET_INVALID  = 2'b00,
    ET_POINTER  = 2'b01,
    ET_LEAF     = 2'b10,
    ET_RESERVED = 2'b11
  } entry_kind_e;

  typedef enum logic [1:0] {
    LV_CTX   = 2'd0,
    LV_ONE   = 2'd1,
    LV_TWO   = 2'd2,
    LV_THREE = 2'd3
  } walk_level_e;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ISSUE = 2'd1,
    WS_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  walk_level_e       level,
  input  logic [BASE_W-1:0] tbl_base,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [VA_W-1:0]   vaddr,
  output logic [PA_W-1:0]   entry_addr
);
  localparam int IDX_W = (CTX_W > L1_IDX_W) ? CTX_W : L1_IDX_W;

  logic [IDX_W-1:0] idx;

  always_comb begin
    case (level)
      LV_CTX:   idx = IDX_W'(ctx);
      LV_ONE:   idx = IDX_W'(vaddr[L1_LO +: L1_IDX_W]);
      LV_TWO:   idx = IDX_W'(vaddr[L2_LO +: L2_IDX_W]);
      LV_THREE: idx = IDX_W'(vaddr[L3_LO +: L3_IDX_W]);
      default:  idx = '0;
    endcase
  end

  assign entry_addr = (PA_W'(tbl_base) << TBL_SHIFT) + (PA_W'(idx) << ENT_SHIFT);
endmodule

// File: rtl/pgw_entry_class.sv
module pgw_entry_class
  import pgw_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  walk_level_e        level,
  output logic               is_fault,
  output logic               is_leaf,
  output logic [BASE_W-1:0]  next_base,
  output logic [PPN_W-1:0]   ppn,
  output logic [PERM_W-1:0]  perm
);
  entry_kind_e kind;

  assign kind = entry_kind_e'(entry[1:0]);

  always_comb begin
    is_fault = 1'b0;
    is_leaf  = 1'b0;
    case (kind)
      ET_POINTER: is_fault = (level == LV_THREE);
      ET_LEAF: begin
        if (level == LV_CTX) is_fault = 1'b1;
        else                 is_leaf  = 1'b1;
      end
      default: is_fault = 1'b1;
    endcase
  end

  assign next_base = entry[ENTRY_W-1:2];
  assign ppn       = entry[PPN_LO +: PPN_W];
  assign perm      = entry[PERM_LO +: PERM_W];
endmodule

// File: rtl/pgw_paddr_merge.sv
module pgw_paddr_merge
  import pgw_pkg::*;
(
  input  walk_level_e      level,
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  vaddr,
  output logic [PA_W-1:0]  paddr
);
  logic [PA_W-1:0] cand [1:3];

  for (genvar g = 1; g <= 3; g++) begin : g_lvl
    localparam int KEEP = OFF_W + ((g < 3) ? L3_IDX_W : 0) + ((g < 2) ? L2_IDX_W : 0);
    assign cand[g] = {ppn[PPN_W-1:KEEP-OFF_W], vaddr[KEEP-1:0]};
  end

  always_comb begin
    case (level)
      LV_ONE:   paddr = cand[1];
      LV_TWO:   paddr = cand[2];
      LV_THREE: paddr = cand[3];
      default:  paddr = '0;
    endcase
  end
endmodule

// File: rtl/hw_pt_walker.sv
module hw_pt_walker
  import pgw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [31:0]          req_vaddr,
  input  logic [CTX_W-1:0]     req_ctx,
  input  logic [29:0]          ctx_tbl_base,
  output logic                 mem_rd_valid,
  input  logic                 mem_rd_ready,
  output logic [35:0]          mem_rd_addr,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_data,
  output logic                 walk_done,
  output logic                 walk_fault,
  output logic [1:0]           fault_level,
  output logic [1:0]           leaf_level,
  output logic [23:0]          leaf_ppn,
  output logic [5:0]           leaf_perm,
  output logic [35:0]          leaf_paddr
);
  walk_state_e        state_q;
  walk_level_e        level_q;
  logic [VA_W-1:0]    va_q;
  logic [CTX_W-1:0]   ctx_q;
  logic [BASE_W-1:0]  base_q;

  logic               done_q, fault_q;
  walk_level_e        flvl_q, llvl_q;
  logic [PPN_W-1:0]   ppn_q;
  logic [PERM_W-1:0]  perm_q;
  logic [PA_W-1:0]    paddr_q;

  logic               cls_fault, cls_leaf;
  logic [BASE_W-1:0]  cls_base;
  logic [PPN_W-1:0]   cls_ppn;
  logic [PERM_W-1:0]  cls_perm;
  logic [PA_W-1:0]    merged_pa;
  logic [PA_W-1:0]    ent_addr;

  pgw_addr_gen #(.CTX_W(CTX_W)) u_addr (
    .level      (level_q),
    .tbl_base   (base_q),
    .ctx        (ctx_q),
    .vaddr      (va_q),
    .entry_addr (ent_addr)
  );

  pgw_entry_class u_class (
    .entry     (mem_rsp_data),
    .level     (level_q),
    .is_fault  (cls_fault),
    .is_leaf   (cls_leaf),
    .next_base (cls_base),
    .ppn       (cls_ppn),
    .perm      (cls_perm)
  );

  pgw_paddr_merge u_merge (
    .level (level_q),
    .ppn   (cls_ppn),
    .vaddr (va_q),
    .paddr (merged_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      level_q <= LV_CTX;
      va_q    <= '0;
      ctx_q   <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= LV_CTX;
      llvl_q  <= LV_CTX;
      ppn_q   <= '0;
      perm_q  <= '0;
      paddr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            ctx_q   <= req_ctx;
            base_q  <= ctx_tbl_base;
            level_q <= LV_CTX;
            state_q <= WS_ISSUE;
          end
        end
        WS_ISSUE: begin
          if (mem_rd_ready) state_q <= WS_WAIT;
        end
        WS_WAIT: begin
          if (mem_rsp_valid) begin
            if (cls_fault) begin
              fault_q <= 1'b1;
              flvl_q  <= level_q;
              state_q <= WS_IDLE;
            end else if (cls_leaf) begin
              done_q  <= 1'b1;
              llvl_q  <= level_q;
              ppn_q   <= cls_ppn;
              perm_q  <= cls_perm;
              paddr_q <= merged_pa;
              state_q <= WS_IDLE;
            end else begin
              base_q  <= cls_base;
              level_q <= walk_level_e'(level_q + 2'd1);
              state_q <= WS_ISSUE;
            end
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == WS_IDLE);
  assign mem_rd_valid = (state_q == WS_ISSUE);
  assign mem_rd_addr  = ent_addr;
  assign walk_done    = done_q;
  assign walk_fault   = fault_q;
  assign fault_level  = flvl_q;
  assign leaf_level   = llvl_q;
  assign leaf_ppn     = ppn_q;
  assign leaf_perm    = perm_q;
  assign leaf_paddr   = paddr_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_READY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (walk_done || walk_fault)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid); // R9
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_fault)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done); // R10
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault |=> !walk_fault); // R10
  AST_LEAF_LEVEL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> (leaf_level != 2'd0)); // R6
endmodule

// File: tb/hw_pt_walker_bench.sv
`timescale 1ns/1ps
module hw_pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_ctx = '0;
  logic [29:0] ctx_tbl_base = 30'h100;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [35:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        walk_done, walk_fault;
  logic [1:0]  fault_level, leaf_level;
  logic [23:0] leaf_ppn;
  logic [5:0]  leaf_perm;
  logic [35:0] leaf_paddr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hw_pt_walker u_hw_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_ctx(req_ctx), .ctx_tbl_base(ctx_tbl_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .walk_done(walk_done), .walk_fault(walk_fault),
    .fault_level(fault_level), .leaf_level(leaf_level),
    .leaf_ppn(leaf_ppn), .leaf_perm(leaf_perm), .leaf_paddr(leaf_paddr)
  );

  localparam logic [29:0] PB1 = 30'h2000;
  localparam logic [29:0] PB2 = 30'h3000;
  localparam logic [29:0] PB3 = 30'h4000;

  // sparse memory model
  logic [35:0] tbl_a [0:15];
  logic [31:0] tbl_d [0:15];
  int          tbl_n = 0;
  logic [35:0] rd_log [0:7];
  int          rd_cnt = 0;
  int          stall_cfg = 0;
  int          stall_left = 0;
  int          lat_cfg = 1;
  int          rsp_cnt = 0;
  logic [35:0] pend_addr = '0;
  bit          prev_stall = 0;
  logic [35:0] prev_addr = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input logic [35:0] a);
    for (int i = 0; i < tbl_n; i++) if (tbl_a[i] == a) return tbl_d[i];
    return 32'h0;
  endfunction

  task automatic put(input logic [35:0] a, input logic [31:0] d);
    tbl_a[tbl_n] = a;
    tbl_d[tbl_n] = d;
    tbl_n++;
  endtask

  function automatic logic [31:0] mk_ptr(input logic [29:0] b);
    return {b, 2'b01};
  endfunction

  function automatic logic [31:0] mk_leaf(input logic [23:0] p, input logic [5:0] pm);
    return {p, pm, 2'b10};
  endfunction

  function automatic logic [35:0] ea(input logic [29:0] b, input logic [7:0] idx);
    return ({6'b0, b} << 4) + (36'(idx) << 2);
  endfunction

  function automatic logic [35:0] exp_addr(input int lv, input logic [31:0] va, input logic [7:0] ctx);
    case (lv)
      0: return ea(ctx_tbl_base, ctx);
      1: return ea(PB1, va[31:24]);
      2: return ea(PB2, {2'b0, va[23:18]});
      default: return ea(PB3, {2'b0, va[17:12]});
    endcase
  endfunction

  function automatic logic [29:0] base_of(input int lv);
    case (lv)
      1: return PB1;
      2: return PB2;
      default: return PB3;
    endcase
  endfunction

  function automatic logic [35:0] exp_pa(input int lv, input logic [23:0] p, input logic [31:0] va);
    case (lv)
      1: return {p[23:12], va[23:0]};
      2: return {p[23:6], va[17:0]};
      default: return {p, va[11:0]};
    endcase
  endfunction

  task automatic build_chain(input logic [31:0] va, input logic [7:0] ctx, input int nptr,
                             input logic [31:0] fin);
    for (int lv = 0; lv < nptr; lv++) put(exp_addr(lv, va, ctx), mk_ptr(base_of(lv + 1)));
    put(exp_addr(nptr, va, ctx), fin);
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (prev_stall && (!mem_rd_valid || mem_rd_addr != prev_addr)) begin
        errors++;
        $display("FAIL R9 stalled read changed: actual %0h expected %0h", mem_rd_addr, prev_addr);
      end
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = lookup(pend_addr);
        end
      end
      if (rst_n && mem_rd_valid) begin
        if (stall_left > 0) begin
          mem_rd_ready = 1'b0;
          stall_left--;
        end else begin
          mem_rd_ready = 1'b1;
          if (rsp_cnt != 0) begin
            errors++;
            $display("FAIL R9 second read while one outstanding: actual %0d expected 0", rsp_cnt);
          end
          if (rd_cnt < 8) rd_log[rd_cnt] = mem_rd_addr;
          rd_cnt++;
          pend_addr  = mem_rd_addr;
          rsp_cnt    = lat_cfg;
          stall_left = stall_cfg;
        end
      end else begin
        mem_rd_ready = 1'b0;
      end
      prev_stall = mem_rd_valid && !mem_rd_ready;
      prev_addr  = mem_rd_addr;
    end
  end

  task automatic issue(input logic [31:0] va, input logic [7:0] ctx);
    req_valid = 1'b1;
    req_vaddr = va;
    req_ctx   = ctx;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_fault);
    int n = 0;
    while (!(walk_done || walk_fault) && n < 300) begin
      @(negedge clk);
      n++;
    end
    got_done  = walk_done;
    got_fault = walk_fault;
  endtask

  task automatic run_case(input string tag, input logic [31:0] va, input logic [7:0] ctx,
                          input int nptr, input logic [31:0] fin,
                          input bit exp_fault, input logic [1:0] exp_lvl);
    bit gd, gf;
    tbl_n = 0;
    rd_cnt = 0;
    build_chain(va, ctx, nptr, fin);
    @(negedge clk);
    issue(va, ctx);
    chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
    wait_end(gd, gf);
    chk(!(gd && gf), "R10", "done and fault together", {gd, gf}, 0);
    chk(req_ready == 1'b1, "R2", "ready back at end pulse", req_ready, 1);
    chk(gf == exp_fault && gd == !exp_fault, tag, "end kind fault/done", {gf, gd}, {exp_fault, !exp_fault});
    if (exp_fault) begin
      chk(fault_level == exp_lvl, tag, "fault level", fault_level, exp_lvl);
    end else begin
      chk(leaf_level == exp_lvl, "R7", "leaf level", leaf_level, exp_lvl);
      chk(leaf_ppn == fin[31:8], "R7", "leaf ppn", leaf_ppn, fin[31:8]);
      chk(leaf_perm == fin[7:2], "R7", "leaf perm", leaf_perm, fin[7:2]);
      chk(leaf_paddr == exp_pa(exp_lvl, fin[31:8], va), "R8", "physical address",
          leaf_paddr, exp_pa(exp_lvl, fin[31:8], va));
    end
    chk(rd_cnt == nptr + 1, "R4", "number of reads", rd_cnt, nptr + 1);
    for (int i = 0; i <= nptr && i < 8; i++)
      chk(rd_log[i] == exp_addr(i, va, ctx), (i == 0) ? "R3" : "R4", "read address",
          rd_log[i], exp_addr(i, va, ctx));
    @(negedge clk);
    chk(!walk_done && !walk_fault, "R10", "end pulse one cycle", {walk_done, walk_fault}, 0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(mem_rd_valid == 1'b0, "R1", "no read after reset", mem_rd_valid, 0);
    chk(walk_done == 1'b0 && walk_fault == 1'b0, "R1", "no end pulse after reset",
        {walk_done, walk_fault}, 0);
  endtask

  task automatic t_full_walk;
    run_case("R7", 32'hA58CD456, 8'd5, 3, mk_leaf(24'h12345A, 6'h2B), 1'b0, 2'd3);
  endtask

  task automatic t_level1_leaf;
    run_case("R7", 32'h3C9A1F0E, 8'd2, 1, mk_leaf(24'hFEDCBA, 6'h15), 1'b0, 2'd1);
  endtask

  task automatic t_level2_leaf;
    run_case("R7", 32'h71F4B333, 8'd9, 2, mk_leaf(24'h0ABCDE, 6'h3F), 1'b0, 2'd2);
  endtask

  task automatic t_invalid_l2;
    run_case("R5", 32'h11223344, 8'd1, 2, 32'h0000_0000, 1'b1, 2'd2);
  endtask

  task automatic t_reserved_l1;
    run_case("R5", 32'h99887766, 8'd7, 1, 32'h0000_ABC3, 1'b1, 2'd1);
  endtask

  task automatic t_ctx_invalid;
    run_case("R5", 32'h55667788, 8'd200, 0, 32'h0000_1000, 1'b1, 2'd0);
  endtask

  task automatic t_ctx_leaf;
    run_case("R6", 32'h01020304, 8'd4, 0, mk_leaf(24'h000111, 6'h01), 1'b1, 2'd0);
  endtask

  task automatic t_ptr_at_l3;
    run_case("R6", 32'hDEADB123, 8'd3, 3, mk_ptr(30'h5000), 1'b1, 2'd3);
  endtask

  task automatic t_stalled_memory;
    stall_cfg = 3;
    stall_left = 3;
    lat_cfg = 4;
    run_case("R9", 32'h6B2E9ABC, 8'd6, 3, mk_leaf(24'h765432, 6'h2A), 1'b0, 2'd3);
    stall_cfg = 0;
    stall_left = 0;
    lat_cfg = 1;
  endtask

  task automatic t_back_to_back;
    logic [31:0] va_a = 32'h4411C5A0;
    logic [31:0] va_b = 32'h8F6D3E21;
    logic [31:0] leaf_a = mk_leaf(24'hA0B0C0, 6'h11);
    logic [31:0] leaf_b = mk_leaf(24'h1D2E3F, 6'h22);
    int n = 0;
    tbl_n = 0;
    rd_cnt = 0;
    build_chain(va_a, 8'd8, 3, leaf_a);
    build_chain(va_b, 8'd8, 2, leaf_b);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va_a;
    req_ctx   = 8'd8;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_vaddr = va_b;
    while (!req_ready && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(walk_done == 1'b1, "R2", "ready rises with done pulse", walk_done, 1);
    chk(leaf_paddr == exp_pa(3, leaf_a[31:8], va_a), "R8", "first walk address",
        leaf_paddr, exp_pa(3, leaf_a[31:8], va_a));
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2", "second request taken at done edge", req_ready, 0);
    begin
      bit gd, gf;
      wait_end(gd, gf);
      chk(gd && !gf, "R7", "second walk completes", {gd, gf}, 2'b10);
    end
    chk(leaf_level == 2'd2, "R7", "second walk level", leaf_level, 2);
    chk(leaf_paddr == exp_pa(2, leaf_b[31:8], va_b), "R8", "second walk address",
        leaf_paddr, exp_pa(2, leaf_b[31:8], va_b));
    chk(rd_cnt == 7, "R9", "reads across both walks", rd_cnt, 7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_full_walk;
    t_level1_leaf;
    t_level2_leaf;
    t_invalid_l2;
    t_reserved_l1;
    t_ctx_invalid;
    t_ctx_leaf;
    t_ptr_at_l3;
    t_stalled_memory;
    t_back_to_back;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule